// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog peripheral behind a simple 32-bit register bus. Software first sets a 64-bit period, which is held as two 32-bit words, and a 64-bit starting count. It also sets a run mode and releases both counter halves from reset. It then arms the watchdog with a fixed pair of 16-bit keys written to the watchdog control word. Once armed, the configuration cannot be changed. The counter then climbs by one per clock. Software has to repeat the same two-key handshake before the counter reaches the period. Each completed handshake returns the count to zero.

There are two ways the watchdog trips. The counter can reach the period, or software can write any key that is not the one the handshake expects next. When the watchdog trips, a sticky timeout flag is set and a registered reset request is raised. Both stay set until the block's own synchronous reset. Reads return registered data one clock after the address is presented.

Top module: `kwdt_top`

## Requirements
- R1: After reset, every register reads zero except the identification word, and `reset_req` is low.
- R2: Register offsets are as follows. 0x00 is the read-only identification word and 0x04 reads zero. 0x10 and 0x14 are the count (low, high) and 0x18 and 0x1C are the period (low, high). 0x20 keeps only the run-mode field in bits [7:6]. 0x24 keeps bits [3:0]. At 0x28, bit 14 is the enable, bit 15 is the timeout flag and bits [31:16] are the key field, which always reads zero.
- R3: While unarmed, a write of key 0xA5C6 with bit 14 set enters the pre-armed state, and a following key 0xDA7E enters the armed counting state. A key written without bit 14 leaves the block unarmed, and no key written while unarmed ever trips it.
- R4: From the pre-armed state onward, writes to the count, period, run-mode and global-control words are ignored, and the enable bit stays set.
- R5: While armed, the counter rises by one per clock only if bits 0 and 1 of 0x24 are both set and the run mode is nonzero. Otherwise it holds.
- R6: The count carries from the low word into the high word.
- R7: While armed, key 0xA5C6 followed by key 0xDA7E is a service. The counter becomes zero at the clock that accepts the second key, and counting resumes.
- R8: A wrong key in the pre-armed, armed or mid-service state trips the watchdog at that clock.
- R9: When the count equals the period while armed, the watchdog trips at the next clock, the flag reads 1 and the count freezes at the period.
- R10: Once tripped, `reset_req` and the flag stay high whatever is written, until `rst`.
- R11: If the second service key arrives at the same clock as the count equals the period, the trip wins and the count is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per asserted clock |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the address of the previous clock |
| reset_req | output | 1 | Sticky registered reset request |

## Verification
A service completion and a period match can land on the same clock edge. The bench provokes this by choosing a period of 3, arming, and issuing the service handshake so that its second key is accepted exactly when the count shows 3. It judges the outcome by `reset_req` being high and the count reading back 3 rather than a small post-service value. With a period of 4 and the same timing, the service succeeds instead, and the count reads back as 1 one clock later.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_RUN  = 3'd2,
    ST_SVC  = 3'd3,
    ST_TRIP = 3'd4
  } wd_state_e;

  localparam logic [7:0] OFF_ID     = 8'h00;
  localparam logic [7:0] OFF_EMU    = 8'h04;
  localparam logic [7:0] OFF_CNT_LO = 8'h10;
  localparam logic [7:0] OFF_PRD_LO = 8'h18;
  localparam logic [7:0] OFF_TCTL   = 8'h20;
  localparam logic [7:0] OFF_GCTL   = 8'h24;
  localparam logic [7:0] OFF_WCTL   = 8'h28;
  localparam int         WORD_BYTES = 4;

  localparam int EN_BIT   = 14;
  localparam int FLAG_BIT = 15;
  localparam int KEY_LSB  = 16;
  localparam int KEY_W    = 16;
  localparam int MODE_LSB = 6;
  localparam int MODE_W   = 2;
  localparam int GCTL_W   = 4;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [31:0] ID_VALUE = 32'h0001_5A17,
  localparam int CNT_W  = 2 * DATA_W,
  localparam int N_HALF = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              locked,
  input  logic              tripped,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  prd,
  output logic              cfg_ok,
  output logic [N_HALF-1:0] cnt_wr,
  output logic              key_wr,
  output logic [KEY_W-1:0]  key_val,
  output logic              en_req,
  output logic [DATA_W-1:0] rdata
);
  logic [MODE_W-1:0] mode_q;
  logic [GCTL_W-1:0] gctl_q;
  logic              en_q;
  logic [DATA_W-1:0] rd_next;
  logic              cfg_we;

  assign cfg_we  = we && !locked;
  assign key_wr  = we && (addr == ADDR_W'(OFF_WCTL));
  assign key_val = wdata[KEY_LSB +: KEY_W];
  assign en_req  = wdata[EN_BIT];
  assign cfg_ok  = gctl_q[0] && gctl_q[1] && (mode_q != '0);

  genvar gi;
  generate
    for (gi = 0; gi < N_HALF; gi++) begin : g_cnt_wr
      assign cnt_wr[gi] = cfg_we && (addr == ADDR_W'(OFF_CNT_LO + WORD_BYTES * gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prd    <= '0;
      mode_q <= '0;
      gctl_q <= '0;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_HALF; i++) begin
        if (addr == ADDR_W'(OFF_PRD_LO + WORD_BYTES * i))
          prd[i*DATA_W +: DATA_W] <= wdata;
      end
      if (addr == ADDR_W'(OFF_TCTL)) mode_q <= wdata[MODE_LSB +: MODE_W];
      if (addr == ADDR_W'(OFF_GCTL)) gctl_q <= wdata[GCTL_W-1:0];
      if (addr == ADDR_W'(OFF_WCTL)) en_q   <= wdata[EN_BIT];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(OFF_ID)) rd_next = DATA_W'(ID_VALUE);
    for (int i = 0; i < N_HALF; i++) begin
      if (addr == ADDR_W'(OFF_CNT_LO + WORD_BYTES * i)) rd_next = cnt[i*DATA_W +: DATA_W];
      if (addr == ADDR_W'(OFF_PRD_LO + WORD_BYTES * i)) rd_next = prd[i*DATA_W +: DATA_W];
    end
    if (addr == ADDR_W'(OFF_TCTL)) rd_next[MODE_LSB +: MODE_W] = mode_q;
    if (addr == ADDR_W'(OFF_GCTL)) rd_next[GCTL_W-1:0] = gctl_q;
    if (addr == ADDR_W'(OFF_WCTL)) begin
      rd_next[EN_BIT]   = en_q;
      rd_next[FLAG_BIT] = tripped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/kwdt_keyfsm.sv
module kwdt_keyfsm
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  input  logic             en_req,
  input  logic             hit,
  output wd_state_e        state,
  output logic             locked,
  output logic             run,
  output logic             svc_clr,
  output logic             tripped,
  output logic             reset_req
);
  wd_state_e nxt;
  logic      trip_now;

  always_comb begin
    nxt      = state;
    svc_clr  = 1'b0;
    trip_now = 1'b0;
    case (state)
      ST_IDLE: if (key_wr && key_val == KEY_FIRST && en_req) nxt = ST_PRE;
      ST_PRE: begin
        if (key_wr) begin
          if (key_val == KEY_SECOND) nxt = ST_RUN;
          else trip_now = 1'b1;
        end
      end
      ST_RUN: begin
        if (hit) trip_now = 1'b1;
        else if (key_wr) begin
          if (key_val == KEY_FIRST) nxt = ST_SVC;
          else trip_now = 1'b1;
        end
      end
      ST_SVC: begin
        if (hit) trip_now = 1'b1;
        else if (key_wr) begin
          if (key_val == KEY_SECOND) begin
            nxt     = ST_RUN;
            svc_clr = 1'b1;
          end else trip_now = 1'b1;
        end
      end
      default: nxt = ST_TRIP;
    endcase
    if (trip_now) nxt = ST_TRIP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      reset_req <= 1'b0;
    end else begin
      state     <= nxt;
      reset_req <= (nxt == ST_TRIP);
    end
  end

  assign locked  = (state != ST_IDLE);
  assign run     = (state == ST_RUN) || (state == ST_SVC);
  assign tripped = (state == ST_TRIP);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int DATA_W = 32,
  localparam int CNT_W  = 2 * DATA_W,
  localparam int N_HALF = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_HALF-1:0] cnt_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              run,
  input  logic              cfg_ok,
  input  logic              svc_clr,
  input  logic [CNT_W-1:0]  prd,
  output logic [CNT_W-1:0]  cnt,
  output logic              hit
);
  assign hit = run && (cnt == prd);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (svc_clr) begin
      cnt <= '0;
    end else if (run && cfg_ok && !hit) begin
      cnt <= cnt + CNT_W'(1);
    end else begin
      for (int i = 0; i < N_HALF; i++) begin
        if (cnt_wr[i]) cnt[i*DATA_W +: DATA_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [31:0] ID_VALUE = 32'h0001_5A17,
  localparam int CNT_W  = 2 * DATA_W,
  localparam int N_HALF = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  wd_state_e         st;
  logic              locked, run, svc_clr, tripped, hit, cfg_ok;
  logic              key_wr, en_req;
  logic [KEY_W-1:0]  key_val;
  logic [N_HALF-1:0] cnt_wr;
  logic [CNT_W-1:0]  cnt, prd;

  kwdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .locked(locked), .tripped(tripped), .cnt(cnt), .prd(prd), .cfg_ok(cfg_ok),
    .cnt_wr(cnt_wr), .key_wr(key_wr), .key_val(key_val), .en_req(en_req),
    .rdata(bus_rdata)
  );

  kwdt_keyfsm u_fsm (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_val(key_val), .en_req(en_req),
    .hit(hit), .state(st), .locked(locked), .run(run), .svc_clr(svc_clr),
    .tripped(tripped), .reset_req(reset_req)
  );

  kwdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .wdata(bus_wdata), .run(run),
    .cfg_ok(cfg_ok), .svc_clr(svc_clr), .prd(prd), .cnt(cnt), .hit(hit)
  );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input wd_state_e         st,
  input logic              locked,
  input logic              run,
  input logic              cfg_ok,
  input logic              svc_clr,
  input logic              hit,
  input logic              key_wr,
  input logic [KEY_W-1:0]  key_val,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  prd,
  input logic              reset_req
);
  logic [KEY_W-1:0] want_key;
  assign want_key = (st == ST_RUN) ? KEY_FIRST : KEY_SECOND;

  // R10
  sticky_req_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req);

  // R8
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (key_wr && locked && st != ST_TRIP && key_val != want_key) |=> reset_req);

  // R9
  reach_period_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (reset_req && $stable(cnt)));

  // R7
  service_zero_chk: assert property (@(posedge clk) disable iff (rst)
    svc_clr |=> (cnt == '0));

  // R4
  period_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && bus_we && bus_addr == ADDR_W'(OFF_PRD_LO)) |=> $stable(prd));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cfg_ok && !hit && !svc_clr) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

bind kwdt_top kwdt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .st(st),
  .locked(locked), .run(run), .cfg_ok(cfg_ok), .svc_clr(svc_clr), .hit(hit),
  .key_wr(key_wr), .key_val(key_val), .cnt(cnt), .prd(prd), .reset_req(reset_req)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
  localparam logic [31:0] ID_VAL = 32'h0001_5A17;
  localparam logic [31:0] ARM0   = 32'hA5C6_4000;
  localparam logic [31:0] ARM1   = 32'hDA7E_4000;
  localparam logic [31:0] SVC0   = 32'hA5C6_0000;
  localparam logic [31:0] SVC1   = 32'hDA7E_0000;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expect_rd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h18, 32'h1234_5678, 32'h1234_5678},
    '{8'h1C, 32'h9ABC_DEF0, 32'h9ABC_DEF0},
    '{8'h10, 32'h0000_0011, 32'h0000_0011},
    '{8'h14, 32'h0000_0022, 32'h0000_0022},
    '{8'h20, 32'hFFFF_FFFF, 32'h0000_00C0},
    '{8'h24, 32'hFFFF_FFFF, 32'h0000_000F},
    '{8'h28, 32'h0000_4000, 32'h0000_4000},
    '{8'h00, 32'hFFFF_FFFF, ID_VAL},
    '{8'h04, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kwdt_top dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] plo, input logic [31:0] gctl, input logic [31:0] tctl);
    wr(8'h18, plo);
    wr(8'h1C, 32'h0);
    wr(8'h20, tctl);
    wr(8'h24, gctl);
  endtask

  task automatic arm();
    wr(8'h28, ARM0);
    wr(8'h28, ARM1);
  endtask

  // difference of two count reads with a gap of 5 idle cycles
  task automatic cnt_delta(output logic [31:0] dlt);
    logic [31:0] a, b;
    rd(8'h10, a);
    repeat (5) @(negedge clk);
    rd(8'h10, b);
    dlt = b - a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 reset_req", {31'b0, reset_req}, 32'h0);
    rd(8'h18, v); check("R1 period low", v, 32'h0);
    rd(8'h10, v); check("R1 count low", v, 32'h0);
    rd(8'h28, v); check("R1 wdctl", v, 32'h0);

    // R2 table-driven register map and field masks while unarmed
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd(VECS[i].addr, v);
      check($sformatf("R2 reg %h", VECS[i].addr), v, VECS[i].expect_rd);
    end
    check("R2 no trip while unarmed", {31'b0, reset_req}, 32'h0);

    // R3 key without enable bit leaves block unarmed
    do_reset();
    cfg(32'h0000_1000, 32'h3, 32'h80);
    wr(8'h28, SVC0);
    wr(8'h28, SVC1);
    rd(8'h28, v); check("R3 unarmed wdctl", v, 32'h0);
    cnt_delta(v); check("R3 unarmed no count", v, 32'h0);
    wr(8'h18, 32'h55);
    rd(8'h18, v); check("R3 still writable", v, 32'h55);
    wr(8'h28, 32'h1111_4000);
    check("R3 idle bad key ignored", {31'b0, reset_req}, 32'h0);

    // R3 / R5 proper arming counts 7 per measured window
    do_reset();
    cfg(32'h0000_1000, 32'h3, 32'h80);
    arm();
    cnt_delta(v); check("R5 counts when armed", v, 32'd7);

    // R5 gating by half reset and by mode
    do_reset();
    cfg(32'h0000_1000, 32'h1, 32'h80);
    arm();
    cnt_delta(v); check("R5 half in reset holds", v, 32'h0);
    do_reset();
    cfg(32'h0000_1000, 32'h3, 32'h00);
    arm();
    cnt_delta(v); check("R5 mode zero holds", v, 32'h0);

    // R4 lock after arming; second key without enable keeps enable
    do_reset();
    cfg(32'h0000_1000, 32'h3, 32'h80);
    wr(8'h28, ARM0);
    wr(8'h28, SVC1);
    rd(8'h28, v); check("R4 enable stays set", v, 32'h0000_4000);
    wr(8'h18, 32'h7);
    rd(8'h18, v); check("R4 period locked", v, 32'h0000_1000);
    wr(8'h24, 32'h0);
    wr(8'h20, 32'h0);
    cnt_delta(v); check("R4 control locked", v, 32'd7);

    // R6 carry into high word
    do_reset();
    wr(8'h10, 32'hFFFF_FFFE);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'h80);
    wr(8'h24, 32'hB);
    arm();
    repeat (3) @(negedge clk);
    rd(8'h14, v); check("R6 high word carry", v, 32'h1);

    // R7 service clears count; read one clock later shows 1
    do_reset();
    cfg(32'h0000_1000, 32'h3, 32'h80);
    arm();
    wr(8'h28, SVC0);
    wr(8'h28, SVC1);
    rd(8'h10, v); check("R7 count after service", v, 32'h1);
    check("R7 no trip", {31'b0, reset_req}, 32'h0);

    // R11 service vs period match, period 4: service wins
    do_reset();
    cfg(32'h4, 32'h3, 32'h80);
    arm();
    wr(8'h28, SVC0);
    wr(8'h28, SVC1);
    check("R11 period 4 no trip", {31'b0, reset_req}, 32'h0);
    rd(8'h10, v); check("R11 period 4 cleared", v, 32'h1);

    // R11 period 3: match on second key clock, trip wins
    do_reset();
    cfg(32'h3, 32'h3, 32'h80);
    arm();
    wr(8'h28, SVC0);
    wr(8'h28, SVC1);
    check("R11 trip wins", {31'b0, reset_req}, 32'h1);
    rd(8'h10, v); check("R11 count frozen", v, 32'h3);

    // R9 period reached
    do_reset();
    cfg(32'h5, 32'h3, 32'h80);
    arm();
    check("R9 before period", {31'b0, reset_req}, 32'h0);
    repeat (10) @(negedge clk);
    check("R9 reset_req", {31'b0, reset_req}, 32'h1);
    rd(8'h28, v); check("R9 flag", v, 32'h0000_C000);
    rd(8'h10, v); check("R9 count frozen", v, 32'h5);

    // R10 sticky until reset
    arm();
    check("R10 sticky", {31'b0, reset_req}, 32'h1);
    rd(8'h28, v); check("R10 flag sticky", v, 32'h0000_C000);
    do_reset();
    check("R10 cleared by rst", {31'b0, reset_req}, 32'h0);

    // R8 wrong key in each armed state
    do_reset();
    cfg(32'h0000_1000, 32'h3, 32'h80);
    wr(8'h28, ARM0);
    check("R8 pre ok", {31'b0, reset_req}, 32'h0);
    wr(8'h28, 32'h1234_4000);
    check("R8 pre-armed bad key", {31'b0, reset_req}, 32'h1);
    do_reset();
    cfg(32'h0000_1000, 32'h3, 32'h80);
    arm();
    wr(8'h28, 32'hBEEF_0000);
    check("R8 armed bad key", {31'b0, reset_req}, 32'h1);
    do_reset();
    cfg(32'h0000_1000, 32'h3, 32'h80);
    arm();
    wr(8'h28, SVC0);
    check("R8 service ok", {31'b0, reset_req}, 32'h0);
    wr(8'h28, SVC0);
    check("R8 service bad key", {31'b0, reset_req}, 32'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule